// File: doc/BRIEF.md
# Luma DC Inverse Hadamard Dequantizer

This block recovers the sixteen luma DC coefficients of a macroblock from their quantized Hadamard-domain form. It takes a 4x4 matrix of signed 16-bit coefficients and a 6-bit quantization parameter. It runs a 4-point butterfly over every row, then over every column of the row results. It then scales each of the sixteen values by a multiplier derived from the quantization parameter, rounds the result and writes it back as a signed 16-bit value.

All sixteen inputs are presented in parallel on one bus together with a single-cycle start strobe. The block is busy for a fixed three-cycle pipeline and raises a one-cycle done pulse when the output bus holds the new results. The multiplier is the modulo-6 scale shifted left by the quotient of QP over 6. A fixed rounding constant and a fixed right shift then apply. One datapath therefore serves every QP value and needs no branch between small and large QP.

Top module: `luma_dc_dequant`

## Requirements
- R1: While reset is held and after its release, done_o and busy_o read 0 and coef_o reads all zeros until the first block completes.
- R2: Coefficient i of a block sits at coef_i[16*i+15:16*i], and element (row, col) has index i = 4*row + col. The result uses the same layout. For a 4-point vector v0..v3, the butterfly yields, in order, v0+v1+v2+v3, v0+v1-v2-v3, v0-v1-v2+v3 and v0-v1+v2-v3. It is applied first to each row, giving new column k. It is then applied to each column of that result, giving new row j.
- R3: Every butterfly sum and difference wraps modulo 2^16, with no saturation.
- R4: The multiplier is S << (Q/6), where Q is qp_i clamped to at most 51 and S is 10, 11, 13, 14, 16 or 18 for Q mod 6 equal to 0, 1, 2, 3, 4 or 5.
- R5: Each transformed value t gives the output (t*M + 2) >>> 2, computed in signed arithmetic of at least 32 bits and then truncated to its low 16 bits.
- R6: A start seen while busy_o is 0 is accepted. busy_o then reads 1 after that edge. done_o rises exactly three edges after the accepting edge, for one cycle, and busy_o falls at the same edge.
- R7: A start seen while busy_o is 1 is ignored. The coefficients and QP present with it do not affect the result in progress.
- R8: coef_o changes only at the edge that raises done_o, and holds its value between completions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled at the rising edge |
| coef_i | input | 256 | Sixteen signed 16-bit input coefficients, row-major |
| qp_i | input | 6 | Quantization parameter |
| busy_o | output | 1 | A block is in progress |
| done_o | output | 1 | One-cycle pulse: coef_o holds new results |
| coef_o | output | 256 | Sixteen signed 16-bit results, row-major |

## Verification
On every cycle, the embedded assertions check the handshake rules. These are: the single-cycle done pulse, busy falling only together with done, acceptance raising busy, a latched QP that stays steady against starts during a block, and an output bus that does not move outside completions. They also check that the multiplier stays within its table range and that the wide product keeps the sign of the coefficient, which shows the accumulator does not overflow. The arithmetic itself can only be shown by the bench's scenarios. Those compare every output lane against an independent matrix model for QP 0, 5, 6, 51 and clamped values. They also use all-maximum and all-minimum inputs that force wraparound, impulses, and random blocks.

// File: rtl/dcq_pkg.sv
// Package: shared widths, types and the per-remainder scale function for the
// luma DC dequantizer. Assumes 4x4 blocks and a QP split into quotient and
// remainder by 6.
package dcq_pkg;

    localparam int DIM       = 4;
    localparam int NUM_COEF  = DIM * DIM;
    localparam int QP_DIV    = 6;

    // Scale factor for a given QP remainder (0..5).
    function automatic logic [4:0] rem_scale(input logic [2:0] rem);
        logic [4:0] s;
        case (rem)
            3'd0:    s = 5'd10;
            3'd1:    s = 5'd11;
            3'd2:    s = 5'd13;
            3'd3:    s = 5'd14;
            3'd4:    s = 5'd16;
            default: s = 5'd18;
        endcase
        return s;
    endfunction

    // Element index for row-major 4x4 storage.
    function automatic int elem_idx(input int row, input int col);
        return row * DIM + col;
    endfunction

endpackage

// File: rtl/dcq_butterfly.sv
// Module: 4-point Hadamard butterfly with wrapping arithmetic.
// Output order: sum of all, (v0+v1)-(v2+v3), (v0-v1)-(v2-v3), (v0-v1)+(v2-v3).
// Assumes: all arithmetic in W bits two's complement, overflow wraps.
module dcq_butterfly #(
    parameter int W = 16
) (
    input  logic [4*W-1:0] vec_i,
    output logic [4*W-1:0] vec_o
);
    logic [W-1:0] v0, v1, v2, v3;
    logic [W-1:0] pair_sum_lo, pair_sum_hi, pair_dif_lo, pair_dif_hi;

    // Unpack the four lanes.
    always_comb begin
        v0 = vec_i[0*W +: W];
        v1 = vec_i[1*W +: W];
        v2 = vec_i[2*W +: W];
        v3 = vec_i[3*W +: W];
    end

    // First butterfly stage: pairwise sums and differences.
    always_comb begin
        pair_sum_lo = v0 + v1;
        pair_sum_hi = v2 + v3;
        pair_dif_lo = v0 - v1;
        pair_dif_hi = v2 - v3;
    end

    // Second butterfly stage, packed in the fixed output order.
    always_comb begin
        vec_o[0*W +: W] = pair_sum_lo + pair_sum_hi;
        vec_o[1*W +: W] = pair_sum_lo - pair_sum_hi;
        vec_o[2*W +: W] = pair_dif_lo - pair_dif_hi;
        vec_o[3*W +: W] = pair_dif_lo + pair_dif_hi;
    end
endmodule

// File: rtl/dcq_scale_lut.sv
// Module: derives the dequantization multiplier from QP.
// The QP is clamped to QP_MAX, split into quotient and remainder by 6, and the
// remainder scale is shifted left by the quotient. Pure combinational logic.
module dcq_scale_lut
    import dcq_pkg::*;
#(
    parameter int QP_W   = 6,
    parameter int QP_MAX = 51,
    parameter int MUL_W  = 16
) (
    input  logic [QP_W-1:0]  qp_i,
    output logic [MUL_W-1:0] mul_o
);
    localparam int MUL_MIN = 10;
    localparam int MUL_MAX = 18 << (QP_MAX / QP_DIV);

    logic [QP_W-1:0] qp_clamped;
    logic [QP_W-1:0] qp_quot;
    logic [2:0]      qp_rem;
    logic [4:0]      scale;

    // Clamp the QP to the legal upper bound.
    always_comb begin
        qp_clamped = (qp_i > QP_W'(QP_MAX)) ? QP_W'(QP_MAX) : qp_i;
    end

    // Split into quotient and remainder by 6.
    always_comb begin
        qp_quot = QP_W'(qp_clamped / QP_W'(QP_DIV));
        qp_rem  = 3'(qp_clamped % QP_W'(QP_DIV));
        scale   = rem_scale(qp_rem);
    end

    // Pre-shift the scale once per block.
    always_comb begin
        mul_o = MUL_W'({{(MUL_W-5){1'b0}}, scale} << qp_quot);
    end

    // R4: the multiplier stays inside the range the table and clamp allow.
    always_comb begin
        a_r4_mul_range: assert (mul_o >= MUL_W'(MUL_MIN) && mul_o <= MUL_W'(MUL_MAX))
            else $error("multiplier out of range: %0d", mul_o);
    end
endmodule

// File: rtl/dcq_dequant_lane.sv
// Module: one dequantization lane: signed coefficient times unsigned multiplier,
// plus rounding constant, arithmetic right shift, truncation to W bits.
// Assumes: ACC_W wide enough for W + MUL_W + 1 bits, multiplier nonzero.
module dcq_dequant_lane #(
    parameter int W      = 16,
    parameter int MUL_W  = 16,
    parameter int ACC_W  = 32,
    parameter int SHIFT  = 2
) (
    input  logic [W-1:0]     coef_i,
    input  logic [MUL_W-1:0] mul_i,
    output logic [W-1:0]     res_o
);
    localparam logic signed [ACC_W-1:0] ROUND = ACC_W'(1) <<< (SHIFT - 1);

    logic signed [ACC_W-1:0] coef_ext;
    logic signed [ACC_W-1:0] mul_ext;
    logic signed [ACC_W-1:0] product;
    logic signed [ACC_W-1:0] rounded;

    // Widen both operands to the accumulator width.
    always_comb begin
        coef_ext = ACC_W'($signed(coef_i));
        mul_ext  = ACC_W'($signed({1'b0, mul_i}));
    end

    // Multiply, round, shift and truncate.
    always_comb begin
        product = coef_ext * mul_ext;
        rounded = product + ROUND;
        res_o   = W'(rounded >>> SHIFT);
    end

    // R5: the wide product keeps the coefficient's sign (no accumulator overflow).
    always_comb begin
        a_r5_no_overflow: assert (coef_ext == '0 || product[ACC_W-1] == coef_i[W-1])
            else $error("dequant product overflow");
    end
endmodule

// File: rtl/luma_dc_dequant.sv
// Module: luma DC inverse Hadamard and dequantizer, top level.
// Pipeline: capture -> row butterflies -> column butterflies -> dequant.
// A start is accepted only while idle; done pulses three edges after acceptance.
// Assumes: synchronous active-low reset, coefficients row-major on packed buses.
module luma_dc_dequant
    import dcq_pkg::*;
#(
    parameter int COEF_W = 16,
    parameter int QP_W   = 6,
    parameter int QP_MAX = 51,
    parameter int MUL_W  = 16,
    parameter int ACC_W  = 32,
    parameter int SHIFT  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [NUM_COEF*COEF_W-1:0] coef_i,
    input  logic [QP_W-1:0]            qp_i,
    output logic                       busy_o,
    output logic                       done_o,
    output logic [NUM_COEF*COEF_W-1:0] coef_o
);
    localparam int STAGES = 3;

    logic [COEF_W-1:0] in_q  [NUM_COEF];
    logic [COEF_W-1:0] row_d [NUM_COEF];
    logic [COEF_W-1:0] row_q [NUM_COEF];
    logic [COEF_W-1:0] col_d [NUM_COEF];
    logic [COEF_W-1:0] col_q [NUM_COEF];
    logic [COEF_W-1:0] deq_d [NUM_COEF];
    logic [QP_W-1:0]   qp_q;
    logic [MUL_W-1:0]  mul;
    logic [STAGES-1:0] stage_q;
    logic              done_q;
    logic              accept;

    // Accept a new block only while no stage is occupied.
    always_comb begin
        accept = start_i && (stage_q == '0);
    end

    // Stage occupancy shift register and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            done_q  <= 1'b0;
        end else begin
            stage_q <= {stage_q[STAGES-2:0], accept};
            done_q  <= stage_q[STAGES-1];
        end
    end

    // Capture inputs and QP on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qp_q <= '0;
            for (int i = 0; i < NUM_COEF; i++) in_q[i] <= '0;
        end else if (accept) begin
            qp_q <= qp_i;
            for (int i = 0; i < NUM_COEF; i++) in_q[i] <= coef_i[i*COEF_W +: COEF_W];
        end
    end

    // Row pass: one butterfly per row, result column k from output lane k.
    for (genvar r = 0; r < DIM; r++) begin : g_row
        logic [DIM*COEF_W-1:0] vin, vout;
        for (genvar c = 0; c < DIM; c++) begin : g_lane
            assign vin[c*COEF_W +: COEF_W] = in_q[r*DIM + c];
            assign row_d[r*DIM + c]         = vout[c*COEF_W +: COEF_W];
        end
        dcq_butterfly #(.W(COEF_W)) i_bfly (.vec_i(vin), .vec_o(vout));
    end

    // Register the row pass results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_COEF; i++) row_q[i] <= '0;
        end else if (stage_q[0]) begin
            for (int i = 0; i < NUM_COEF; i++) row_q[i] <= row_d[i];
        end
    end

    // Column pass: one butterfly per column, result row j from output lane j.
    for (genvar k = 0; k < DIM; k++) begin : g_col
        logic [DIM*COEF_W-1:0] vin, vout;
        for (genvar j = 0; j < DIM; j++) begin : g_lane
            assign vin[j*COEF_W +: COEF_W] = row_q[j*DIM + k];
            assign col_d[j*DIM + k]         = vout[j*COEF_W +: COEF_W];
        end
        dcq_butterfly #(.W(COEF_W)) i_bfly (.vec_i(vin), .vec_o(vout));
    end

    // Register the column pass results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_COEF; i++) col_q[i] <= '0;
        end else if (stage_q[1]) begin
            for (int i = 0; i < NUM_COEF; i++) col_q[i] <= col_d[i];
        end
    end

    dcq_scale_lut #(.QP_W(QP_W), .QP_MAX(QP_MAX), .MUL_W(MUL_W)) i_lut (
        .qp_i  (qp_q),
        .mul_o (mul)
    );

    // Sixteen dequantization lanes sharing one multiplier.
    for (genvar i = 0; i < NUM_COEF; i++) begin : g_deq
        dcq_dequant_lane #(
            .W(COEF_W), .MUL_W(MUL_W), .ACC_W(ACC_W), .SHIFT(SHIFT)
        ) i_lane (
            .coef_i (col_q[i]),
            .mul_i  (mul),
            .res_o  (deq_d[i])
        );
    end

    // Output register, loaded only at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coef_o <= '0;
        end else if (stage_q[STAGES-1]) begin
            for (int i = 0; i < NUM_COEF; i++) coef_o[i*COEF_W +: COEF_W] <= deq_d[i];
        end
    end

    // Drive handshake outputs.
    always_comb begin
        busy_o = (stage_q != '0);
        done_o = done_q;
    end

    // R6: done lasts one cycle.
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: busy falls only together with done.
    a_r6_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R6: an idle start raises busy.
    a_r6_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R7: a start during a block leaves the latched QP untouched.
    a_r7_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> $stable(qp_q));

    // R8: outputs move only with done.
    a_r8_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(coef_o));
endmodule

// File: tb/test_luma_dc_dequant.sv
module test_luma_dc_dequant;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [255:0] coef_i = '0;
    logic [5:0]   qp_i = '0;
    logic         busy_o, done_o;
    logic [255:0] coef_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] last_exp [16];

    always #2 clk = ~clk;

    luma_dc_dequant i_luma_dc_dequant (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .coef_i(coef_i),
        .qp_i(qp_i), .busy_o(busy_o), .done_o(done_o), .coef_o(coef_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Sign of Hadamard matrix entry (output index a, input index b).
    function automatic int hsgn(input int a, input int b);
        case (a)
            0: return 1;
            1: return (b < 2) ? 1 : -1;
            2: return (b == 0 || b == 3) ? 1 : -1;
            default: return (b == 0 || b == 2) ? 1 : -1;
        endcase
    endfunction

    function automatic logic [15:0] deq_ref(input logic [15:0] t, input int qp);
        int q, s, m;
        longint p, y;
        q = (qp > 51) ? 51 : qp;
        case (q % 6)
            0: s = 10; 1: s = 11; 2: s = 13; 3: s = 14; 4: s = 16; default: s = 18;
        endcase
        m = s << (q / 6);
        p = longint'($signed(t)) * longint'(m);
        y = (p + 2) >>> 2;
        return y[15:0];
    endfunction

    task automatic model(input logic [15:0] x[16], input int qp, output logic [15:0] y[16]);
        for (int j = 0; j < 4; j++)
            for (int k = 0; k < 4; k++) begin
                int acc = 0;
                for (int r = 0; r < 4; r++)
                    for (int c = 0; c < 4; c++)
                        acc += hsgn(j, r) * hsgn(k, c) * int'($signed(x[r*4+c]));
                y[j*4+k] = deq_ref(acc[15:0], qp);
            end
    endtask

    task automatic drive(input logic [15:0] x[16], input int qp);
        for (int i = 0; i < 16; i++) coef_i[i*16 +: 16] = x[i];
        qp_i = 6'(qp);
    endtask

    task automatic compare(input logic [15:0] y[16], input string req);
        for (int i = 0; i < 16; i++) check(req, 32'(coef_o[i*16 +: 16]), 32'(y[i]));
    endtask

    // Run one block with exact cycle checks; req names the data requirement.
    task automatic run_block(input logic [15:0] x[16], input int qp, input string req);
        logic [15:0] y[16];
        model(x, qp, y);
        @(negedge clk); drive(x, qp); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        check("R6 busy after accept", 32'(busy_o), 1);
        @(negedge clk); check("R6 no early done", 32'(done_o), 0);
        @(negedge clk); check("R6 no early done", 32'(done_o), 0);
        @(negedge clk);
        check("R6 done at third edge", 32'(done_o), 1);
        check("R6 busy cleared", 32'(busy_o), 0);
        compare(y, req);
        @(negedge clk);
        check("R6 done one cycle", 32'(done_o), 0);
        compare(y, "R8 output held");
        last_exp = y;
    endtask

    task automatic main;
        logic [15:0] x[16], b[16], y[16];
        repeat (4) @(negedge clk);
        check("R1 done in reset", 32'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after reset", 32'(done_o), 0);
        check("R1 busy after reset", 32'(busy_o), 0);
        check("R1 coef zero", coef_o[31:0], 0);
        check("R1 coef zero hi", coef_o[255:224], 0);

        // Impulse at (1,2): exercises ordering of passes and lanes.
        foreach (x[i]) x[i] = '0;
        x[6] = 16'd100;
        run_block(x, 0, "R2 impulse");
        foreach (x[i]) x[i] = 16'(i * 37 - 200);
        run_block(x, 5, "R2 ramp qp5");
        run_block(x, 6, "R4 qp6");
        run_block(x, 51, "R4 qp51");
        run_block(x, 60, "R4 clamp qp60");
        foreach (x[i]) x[i] = 16'h7fff;
        run_block(x, 0, "R3 wrap max");
        run_block(x, 51, "R5 max qp51");
        foreach (x[i]) x[i] = 16'h8000;
        run_block(x, 51, "R3 wrap min");
        foreach (x[i]) x[i] = (i % 2) ? 16'h8000 : 16'h7fff;
        run_block(x, 50, "R5 alternating extremes");
        foreach (x[i]) x[i] = 16'hffff;
        run_block(x, 1, "R5 negative rounding");

        // R7: starts during a block are ignored.
        foreach (x[i]) x[i] = 16'(i * 11 + 3);
        foreach (b[i]) b[i] = 16'(5000 - i * 700);
        model(x, 20, y);
        @(negedge clk); drive(x, 20); start_i = 1'b1;
        @(negedge clk); drive(b, 44);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk); start_i = 1'b0;
        check("R7 done for first block", 32'(done_o), 1);
        compare(y, "R7 start ignored while busy");
        @(negedge clk);
        check("R7 no second block", 32'(busy_o), 0);
        repeat (3) @(negedge clk);
        check("R8 no spurious done", 32'(done_o), 0);
        compare(y, "R8 hold while idle");

        // Random blocks with a fixed seed.
        void'($urandom(32'd1234));
        for (int n = 0; n < 200; n++) begin
            foreach (x[i]) x[i] = 16'($urandom);
            run_block(x, int'($urandom % 64), "R5 random");
        end
    endtask

    initial begin
        fork
            main();
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule